// File: doc/BRIEF.md
# SMBus Indexed Block-Access Target

This block is a target on a two-wire SMBus. The bus clock and data lines come in as plain input levels, and the data line is driven through an open-drain pull-down enable. Behind the target sits a byte-addressed register space of 256 entries, which the block reaches through a combinational read port and a one-cycle write strobe. Every transfer is framed by a byte count.

In a write, the host sends the target address with the write bit, then a start offset, then a byte count, then that many data bytes. The bytes land at consecutive offsets. In a read, the host sets the offset the same way and then issues a repeated start with the read bit. The target first returns a count byte, taken from a count register at a fixed offset of the register space that the host programs with an ordinary block write. It then returns data from the stored offset onward, for as long as the host acknowledges.

Both lines pass through two-flop synchronizers. Start and stop conditions are recognised from data-line edges that occur while the clock is high. The level on the address-select input picks one of two 7-bit addresses. That level is captured while reset is asserted and is held afterwards.

The controller states and their transitions are listed below. Every state moves to `ST_ADDR` on a start and to `ST_IDLE` on a stop.

- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte. On the 8th clock fall it goes to `ST_ADDR_ACK` if the address matches, or to `ST_WAIT` if it does not.
- `ST_ADDR_ACK`: drives the acknowledge. At the end of the 9th clock it goes to `ST_TX` if the read bit was set, or to `ST_OFFS` if not.
- `ST_OFFS`: receives the offset byte, then goes to `ST_OFFS_ACK`.
- `ST_OFFS_ACK`: acknowledges the offset, then goes to `ST_CNT`.
- `ST_CNT`: receives the byte count, then goes to `ST_CNT_ACK`.
- `ST_CNT_ACK`: acknowledges the count, then goes to `ST_WDATA`.
- `ST_WDATA`: receives a data byte. If the remaining count is not zero it goes to `ST_WDATA_ACK`; otherwise it goes to `ST_WAIT`.
- `ST_WDATA_ACK`: acknowledges the data byte, then returns to `ST_WDATA`.
- `ST_TX`: sends a byte, then goes to `ST_TX_ACK`.
- `ST_TX_ACK`: samples the host's acknowledge. On an acknowledge it returns to `ST_TX`; on a not-acknowledge it goes to `ST_WAIT`.
- `ST_WAIT`: keeps the data line released until a start or a stop.

Top module: `smb_block_target`

## Requirements
- R1: The target acknowledges an address byte whose upper 7 bits equal its own address and whose bit 0 is the direction (0 write, 1 read). For any other address it leaves SDA released for the rest of the transfer.
- R2: In a write, the offset byte and the count byte are acknowledged. Each of the following data bytes, up to the count, is acknowledged and produces exactly one single-cycle write strobe, at offsets N, N+1, and so on, in order.
- R3: Data bytes beyond the count, including every data byte when the count is 0, are not acknowledged and produce no write strobe.
- R4: In a read after a repeated start, the first byte returned is the register at the count offset (default 0x0C). The data bytes that follow come from offsets N, N+1, and so on, while the host acknowledges.
- R5: After the host's not-acknowledge, SDA stays released until the next start or stop, so any further bytes clocked out read as 0xFF.
- R6: The offset is 8 bits wide and wraps from 0xFF to 0x00, for both writes and reads.
- R7: A start detected in the middle of a byte abandons the current transfer without any write strobe and begins address reception again.
- R8: After a stop the target ignores clock pulses and acknowledges nothing until a new start.
- R9: SDA pull-down changes only while the synchronized SCL is low, and an acknowledge stays asserted for the whole high phase of the 9th clock.
- R10: The address is 0x6A when the address-select level captured during reset is 0, and 0x6B when it is 1. Changes on that input after reset have no effect.
- R11: During reset SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; the address-select level is captured while it is low |
| addr_sel | input | 1 | Picks one of the two target addresses |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 drives the data line low (open-drain enable) |
| rd_offs | output | 8 | Register-space read offset |
| rd_data | input | 8 | Register-space read data for `rd_offs`, combinational |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_offs | output | 8 | Register write offset |
| wr_data | output | 8 | Register write data |

## Verification
The bench aims at five boundaries:

- **Count limit.** It sends a data byte beyond the count, and a count of zero. A target that trusts the stream instead of the count would acknowledge these bytes and write them.
- **Offset wrap.** It runs a block that crosses offset 0xFF. An offset that does not wrap would leave the data outside the 8-bit space, so the register model would receive the wrong offsets.
- **Mid-byte start.** It aborts the offset byte with a repeated start halfway through. A target that kept its bit count would take a misaligned offset, and the strobe check would catch it.
- **Read ordering.** It checks that the count byte comes before the data. A target that skipped it would shift every read byte by one.
- **Address capture.** It moves the address-select input after reset, after the address was captured under reset. A target that followed the live level would acknowledge the wrong address.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;
    localparam int BIT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } smbt_state_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/smb_block_target.sv
module smb_block_target
    import smbt_pkg::*;
#(
    parameter logic [DEV_W-1:0]  ADDR_SEL0   = 7'h6A,
    parameter logic [DEV_W-1:0]  ADDR_SEL1   = 7'h6B,
    parameter logic [BYTE_W-1:0] CNT_OFFS    = 8'h0C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rd_offs,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_offs,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    smb_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    smbt_state_t       state, nstate;
    logic [BIT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg, offs, wcnt;
    logic              host_ack, sel_q;
    logic [DEV_W-1:0]  my_addr;
    logic              byte_end;

    // address-select level captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= addr_sel;
    end
    assign my_addr  = sel_q ? ADDR_SEL1 : ADDR_SEL0;
    assign byte_end = scl_fall && (bitcnt == LAST_BIT);

    // next-state logic
    always_comb begin
        nstate = state;
        if (stop_det)       nstate = ST_IDLE;
        else if (start_det) nstate = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (byte_end) nstate = (shreg[BYTE_W-1:1] == my_addr) ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) nstate = shreg[0] ? ST_TX : ST_OFFS;
                ST_OFFS:      if (byte_end) nstate = ST_OFFS_ACK;
                ST_OFFS_ACK:  if (scl_fall) nstate = ST_CNT;
                ST_CNT:       if (byte_end) nstate = ST_CNT_ACK;
                ST_CNT_ACK:   if (scl_fall) nstate = ST_WDATA;
                ST_WDATA:     if (byte_end) nstate = (wcnt != '0) ? ST_WDATA_ACK : ST_WAIT;
                ST_WDATA_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_TX:        if (byte_end) nstate = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) nstate = host_ack ? ST_TX : ST_WAIT;
                ST_WAIT:      nstate = ST_WAIT;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // shift register, bit counter, offset and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            offs     <= '0;
            wcnt     <= '0;
            host_ack <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_end) begin
                        bitcnt <= '0;
                        if (state == ST_OFFS) offs <= shreg;
                        if (state == ST_CNT)  wcnt <= shreg;
                        if (state == ST_WDATA && wcnt != '0) begin
                            offs <= offs + 1'b1;
                            wcnt <= wcnt - 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && shreg[0]) begin
                        shreg  <= rd_data;
                        bitcnt <= '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 1'b1;
                    if (byte_end)      bitcnt <= '0;
                    else if (scl_fall) shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                end
                ST_TX_ACK: begin
                    if (scl_rise) host_ack <= ~sda_s;
                    if (scl_fall && host_ack) begin
                        shreg <= rd_data;
                        offs  <= offs + 1'b1;
                    end
                end
                default: bitcnt <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_offs <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= (state == ST_WDATA) && byte_end && (wcnt != '0) && !start_det && !stop_det;
            wr_offs <= offs;
            wr_data <= shreg;
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_OFFS_ACK, ST_CNT_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_TX:   sda_pull = ~shreg[BYTE_W-1];
            default: sda_pull = 1'b0;
        endcase
    end

    assign rd_offs = (state == ST_ADDR_ACK) ? CNT_OFFS : offs;
endmodule

// File: rtl/smb_block_target_chk.sv
module smb_block_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_pull,
    input logic start_det,
    input logic stop_det,
    input logic wr_en
);
    AST_PULL_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s); // R9

    AST_PULL_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull)); // R9

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull); // R8

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2

    AST_NO_WRITE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !wr_en); // R7
endmodule

bind smb_block_target smb_block_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
    .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en));

// File: tb/smb_block_target_test.sv
module smb_block_target_test;
    typedef logic [7:0] byte_q_t[$];

    localparam int         H     = 10;
    localparam logic [6:0] DEV0  = 7'h6A;
    localparam logic [6:0] DEV1  = 7'h6B;
    localparam logic [7:0] CNTO  = 8'h0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_h = 1'b1, sda_h = 1'b1;
    logic scl_in, sda_in, sda_pull, wr_en;
    logic [7:0] rd_offs, rd_data, wr_offs, wr_data;

    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] exp_q   [$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign scl_in  = scl_h;
    assign sda_in  = sda_h & ~sda_pull;
    assign rd_data = mem[rd_offs];

    smb_block_target #(.ADDR_SEL0(DEV0), .ADDR_SEL1(DEV1), .CNT_OFFS(CNTO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl_in), .sda_in(sda_in),
        .sda_pull(sda_pull), .rd_offs(rd_offs), .rd_data(rd_data),
        .wr_en(wr_en), .wr_offs(wr_offs), .wr_data(wr_data));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // register-space model and per-clock strobe comparison
    always @(negedge clk) begin
        logic [15:0] e;
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected write strobe", {wr_offs, wr_data}, 0);
            end else begin
                e = exp_q.pop_front();
                chk({wr_offs, wr_data} == e, "R2 write strobe offset/data", {wr_offs, wr_data}, e);
            end
            mem[wr_offs] = wr_data;
        end
    end

    task automatic hwait();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hwait();
        scl_h = 1'b1; hwait();
        sda_h = 1'b0; hwait();
        scl_h = 1'b0; hwait();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hwait();
        scl_h = 1'b1; hwait();
        sda_h = 1'b1; hwait();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; hwait();
        scl_h = 1'b1; hwait();
        scl_h = 1'b0; hwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic held);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_h = 1'b1; hwait();
        scl_h = 1'b1;
        repeat (2) @(negedge clk);
        s1 = sda_in;
        repeat (H - 2) @(negedge clk);
        s2 = sda_in;
        scl_h = 1'b0; hwait();
        acked = !s1;
        held  = (s1 == s2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hwait();
            scl_h = 1'b1;
            repeat (H / 2) @(negedge clk);
            b[i] = sda_in;
            repeat (H - H / 2) @(negedge clk);
            scl_h = 1'b0;
        end
        hwait();
        sda_h = !give_ack; hwait();
        scl_h = 1'b1; hwait();
        scl_h = 1'b0; hwait();
        sda_h = 1'b1;
    endtask

    task automatic do_reset(input logic sel);
        rst_n = 1'b0; addr_sel = sel;
        scl_h = 1'b1; sda_h = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0, "R11 reset releases SDA", sda_pull, 0);
        chk(wr_en == 1'b0, "R11 no strobe in reset", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic xfer_write(input logic [6:0] dev, input logic [7:0] offs, input logic [7:0] cnt, input byte_q_t data);
        logic a, h;
        logic [7:0] o;
        bus_start();
        send_byte({dev, 1'b0}, a, h);
        chk(a, "R1 own address acknowledged", a, 1);
        chk(h, "R9 acknowledge held through high phase", h, 1);
        send_byte(offs, a, h);
        chk(a && h, "R2 offset acknowledged", {a, h}, 3);
        send_byte(cnt, a, h);
        chk(a && h, "R2 count acknowledged", {a, h}, 3);
        foreach (data[i]) begin
            o = offs + 8'(i);
            if (i < int'(cnt)) begin
                exp_q.push_back({o, data[i]});
                exp_mem[o] = data[i];
                send_byte(data[i], a, h);
                chk(a && h, "R2 data byte acknowledged", {a, h}, 3);
            end else begin
                send_byte(data[i], a, h);
                chk(!a, "R3 byte beyond count not acknowledged", a, 0);
            end
        end
        bus_stop();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 every expected strobe seen", exp_q.size(), 0);
    endtask

    task automatic xfer_read(input logic [6:0] dev, input logic [7:0] offs, input int nbytes, input string tag);
        logic a, h;
        logic [7:0] b, o;
        bus_start();
        send_byte({dev, 1'b0}, a, h);
        chk(a, "R1 own address acknowledged", a, 1);
        send_byte(offs, a, h);
        chk(a, "R4 read offset acknowledged", a, 1);
        bus_start();
        send_byte({dev, 1'b1}, a, h);
        chk(a && h, "R4 read address acknowledged", {a, h}, 3);
        recv_byte(1'b1, b);
        chk(b == exp_mem[CNTO], "R4 count byte first", b, exp_mem[CNTO]);
        for (int i = 0; i < nbytes; i++) begin
            o = offs + 8'(i);
            recv_byte(i < nbytes - 1, b);
            chk(b == exp_mem[o], tag, b, exp_mem[o]);
        end
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R5 SDA released after host not-acknowledge", b, 8'hFF);
        bus_stop();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        logic a, h;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        do_reset(1'b0);
        addr_sel = 1'b1;   // R10: must not matter after reset

        // program the count register, then a block with one surplus byte
        xfer_write(DEV0, CNTO, 8'd1, '{8'h03});
        xfer_write(DEV0, 8'h20, 8'd3, '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
        xfer_read(DEV0, 8'h20, 3, "R4 read data in order");

        // R1: foreign address is ignored
        bus_start();
        send_byte({DEV1, 1'b0}, a, h);
        chk(!a, "R1 foreign address not acknowledged", a, 0);
        send_byte(8'h30, a, h);
        chk(!a, "R1 no acknowledge after foreign address", a, 0);
        bus_stop();

        // R6: write and read across the wrap point
        xfer_write(DEV0, 8'hFE, 8'd3, '{8'h11, 8'h22, 8'h33});
        chk(mem[8'h00] == 8'h33, "R6 offset wrapped to 0x00", mem[8'h00], 8'h33);
        xfer_read(DEV0, 8'hFE, 3, "R6 read across wrap");

        // R3: count of zero accepts no data
        xfer_write(DEV0, 8'h50, 8'd0, '{8'h99});

        // R7: repeated start halfway through the offset byte
        bus_start();
        send_byte({DEV0, 1'b0}, a, h);
        chk(a, "R7 address before abort acknowledged", a, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        xfer_write(DEV0, 8'h40, 8'd1, '{8'h77});
        chk(mem[8'h40] == 8'h77, "R7 transfer after abort lands at its offset", mem[8'h40], 8'h77);

        // R8: no response between a stop and the next start
        bus_start();
        send_byte({DEV0, 1'b0}, a, h);
        bus_stop();
        scl_h = 1'b0; hwait();
        send_byte({DEV0, 1'b0}, a, h);
        chk(!a, "R8 byte after stop not acknowledged", a, 0);
        send_byte(8'h60, a, h);
        chk(!a, "R8 still idle", a, 0);
        bus_stop();

        // R10: select captured under reset
        do_reset(1'b1);
        addr_sel = 1'b0;
        bus_start();
        send_byte({DEV0, 1'b0}, a, h);
        chk(!a, "R10 low-select address rejected after capture of 1", a, 0);
        bus_stop();
        xfer_write(DEV1, 8'h70, 8'd2, '{8'h5C, 8'hC5});
        xfer_read(DEV1, 8'h70, 2, "R10 read at high-select address");

        repeat (20) @(negedge clk);
        finish_test();
    end
endmodule